// File: doc/BRIEF.md
# Multicycle Processor Core with Step Sequencer

This block is a 32-bit processor core that executes a small integer instruction subset: register-to-register add, subtract, and, or and set-less-than; add-immediate; word load and store; branch-if-equal; and an absolute jump. Every instruction is broken into steps of one clock each. A single memory holds both the program and its data, and at most one access is made to it per clock. One ALU does all the adding: the program counter increment, the branch target sum, the address sum and the operation itself, each in a different step. Values that one step passes to the next wait in internal holding registers.

A step register in the controller selects which step runs next. The path through the steps differs for each instruction class, so a branch or jump takes three clocks, a store or an arithmetic instruction takes four, and a load takes five. Memory is filled through a load port while the core is held in reset. After each instruction completes, the core raises a retire strobe for one clock. It also presents its register-file write and memory write on trace outputs, so the caller can follow the architectural effect of each instruction.

Top module: `mc_core`

## Requirements
- R1: While `rst_n` is low, `pc_o` is 0 and `retire_o`, `rf_we_o` and `mem_we_o` are 0. Words written through the load port during reset land at word index `load_addr`. After reset is released, the first instruction is fetched from byte address 0.
- R2: Each instruction starts with a fetch step. In the clock after the fetch, `pc_o` equals the fetch address plus 4, and `pc_o` is always word aligned.
- R3: A register instruction has opcode bits[31:26] = 0. Its fields are rs = bits[25:21], rt = bits[20:16], rd = bits[15:11] and funct = bits[5:0]. It takes 4 clocks and writes rd in its 4th clock. The funct codes are: 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, 0x2A signed set-less-than giving 1 or 0. Any other funct behaves as add.
- R4: A load (opcode 0x23) takes 5 clocks. In its 5th clock it writes the memory word at rs + sign-extended bits[15:0] to rt.
- R5: A store (opcode 0x2B) takes 4 clocks. In its 4th clock it writes the value of rt to the byte address rs + sign-extended bits[15:0], which is shown on `mem_addr_o`. It writes no register.
- R6: Add-immediate (opcode 0x08) takes 4 clocks. In its 4th clock it writes rs + sign-extended bits[15:0] to rt.
- R7: Branch-if-equal (opcode 0x04) takes 3 clocks. When rs equals rt, the next fetch is from fetch address + 4 + (sign-extended offset × 4). Otherwise the next fetch is from fetch address + 4.
- R8: Jump (opcode 0x02) takes 3 clocks. The next fetch is from {(fetch address + 4)[31:28], bits[25:0], 2'b00}.
- R9: Register 0 always reads as zero, even after an instruction has written to it.
- R10: Any other opcode spends 2 clocks, retires nothing, writes nothing, and is followed by a fetch from its address + 4.
- R11: `retire_o` is high for exactly one clock, the last clock of each recognised instruction. `rf_we_o` and `mem_we_o` are never high together.
- R12: Memory is indexed by byte-address bits [MEM_AW+1:2]. The address bits above these are ignored, so addresses wrap at the memory size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_en | input | 1 | Memory preload write enable |
| load_addr | input | MEM_AW | Word index of the preload write |
| load_data | input | 32 | Preload word |
| pc_o | output | 32 | Current program counter |
| retire_o | output | 1 | One-clock strobe when an instruction completes |
| rf_we_o | output | 1 | Register file write this clock |
| rf_waddr_o | output | 5 | Register written |
| rf_wdata_o | output | 32 | Value written to the register |
| mem_we_o | output | 1 | Store write to memory this clock |
| mem_addr_o | output | 32 | Full byte address of the store |
| mem_wdata_o | output | 32 | Store data |

## Verification
The bench builds the core with `MEM_WORDS` = 64. At this size, a store to byte address 0x1C0 wraps onto the word that a later load reads at 0xC0, so the address aliasing of R12 can be reached by a short program. The program uses every opcode and funct code. It contains a taken and an untaken branch, a jump over skipped code, a load with a negative offset, a write to register 0, and an unknown opcode. A behavioural instruction-level model runs beside the core and predicts, for every clock, the program counter, the retire strobe and the write traces.

// File: rtl/mc_pkg.sv
package mc_pkg;

    localparam int XW  = 32;
    localparam int RAW = 5;

    localparam logic [5:0] OPC_REG  = 6'h00;
    localparam logic [5:0] OPC_JMP  = 6'h02;
    localparam logic [5:0] OPC_BEQ  = 6'h04;
    localparam logic [5:0] OPC_ADDI = 6'h08;
    localparam logic [5:0] OPC_LW   = 6'h23;
    localparam logic [5:0] OPC_SW   = 6'h2B;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef enum logic [3:0] {
        ST_FETCH, ST_DECODE, ST_ALU_R, ST_ADDR, ST_ALU_I, ST_BRANCH,
        ST_JUMP, ST_LOAD, ST_STORE, ST_WB_R, ST_WB_I, ST_WB_LOAD
    } step_e;

    typedef enum logic [2:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT} alu_fn_e;
    typedef enum logic [1:0] {SRCB_REG, SRCB_FOUR, SRCB_IMM, SRCB_IMM_X4} srcb_e;
    typedef enum logic [1:0] {PCSEL_ALU, PCSEL_HELD, PCSEL_JUMP} pcsel_e;

    typedef struct packed {
        logic    pc_wr;
        logic    pc_wr_cond;
        logic    addr_data;
        logic    mem_rd;
        logic    mem_wr;
        logic    ir_wr;
        logic    wb_mem;
        logic    dst_rd;
        logic    reg_wr;
        logic    srca_reg;
        srcb_e   srcb;
        pcsel_e  pcsel;
        alu_fn_e alu_fn;
        logic    retire;
    } ctl_t;

    typedef struct packed {
        logic [XW-1:0] pc;
        logic [XW-1:0] ir;
        logic [XW-1:0] mdr;
        logic [XW-1:0] a;
        logic [XW-1:0] b;
        logic [XW-1:0] aluout;
    } dp_t;

endpackage

// File: rtl/mc_alu.sv
module mc_alu
    import mc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_fn_e      fn,
    output logic [W-1:0] y,
    output logic         zero
);
    logic lt;

    always_comb begin
        lt = ($signed(a) < $signed(b));
        unique case (fn)
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SLT: y = {{(W-1){1'b0}}, lt};
            default: y = a + b;
        endcase
        zero = (y == '0);
    end
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
    parameter  int W  = 32,
    parameter  int N  = 32,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    output logic [W-1:0]  rd1,
    output logic [W-1:0]  rd2,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd
);
    logic [W-1:0] regs_q [N];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) regs_q[i] <= '0;
        end else if (we && (wa != '0)) begin
            regs_q[wa] <= wd;
        end
    end

    assign rd1 = (ra1 == '0) ? '0 : regs_q[ra1];
    assign rd2 = (ra2 == '0) ? '0 : regs_q[ra2];
endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
    import mc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctl_t       ctl,
    output step_e      step
);
    step_e step_d, step_q;

    function automatic alu_fn_e reg_fn(input logic [5:0] f);
        case (f)
            FN_SUB:  return ALU_SUB;
            FN_AND:  return ALU_AND;
            FN_OR:   return ALU_OR;
            FN_SLT:  return ALU_SLT;
            default: return ALU_ADD;
        endcase
    endfunction

    always_comb begin
        step_d = step_q;
        ctl    = '0;
        unique case (step_q)
            ST_FETCH: begin
                ctl.mem_rd = 1'b1;
                ctl.ir_wr  = 1'b1;
                ctl.srcb   = SRCB_FOUR;
                ctl.pc_wr  = 1'b1;
                step_d     = ST_DECODE;
            end
            ST_DECODE: begin
                ctl.srcb = SRCB_IMM_X4;
                case (opcode)
                    OPC_REG:       step_d = ST_ALU_R;
                    OPC_LW, OPC_SW: step_d = ST_ADDR;
                    OPC_ADDI:      step_d = ST_ALU_I;
                    OPC_BEQ:       step_d = ST_BRANCH;
                    OPC_JMP:       step_d = ST_JUMP;
                    default:       step_d = ST_FETCH;
                endcase
            end
            ST_ALU_R: begin
                ctl.srca_reg = 1'b1;
                ctl.srcb     = SRCB_REG;
                ctl.alu_fn   = reg_fn(funct);
                step_d       = ST_WB_R;
            end
            ST_ADDR: begin
                ctl.srca_reg = 1'b1;
                ctl.srcb     = SRCB_IMM;
                step_d       = (opcode == OPC_LW) ? ST_LOAD : ST_STORE;
            end
            ST_ALU_I: begin
                ctl.srca_reg = 1'b1;
                ctl.srcb     = SRCB_IMM;
                step_d       = ST_WB_I;
            end
            ST_BRANCH: begin
                ctl.srca_reg   = 1'b1;
                ctl.srcb       = SRCB_REG;
                ctl.alu_fn     = ALU_SUB;
                ctl.pc_wr_cond = 1'b1;
                ctl.pcsel      = PCSEL_HELD;
                ctl.retire     = 1'b1;
                step_d         = ST_FETCH;
            end
            ST_JUMP: begin
                ctl.pc_wr  = 1'b1;
                ctl.pcsel  = PCSEL_JUMP;
                ctl.retire = 1'b1;
                step_d     = ST_FETCH;
            end
            ST_LOAD: begin
                ctl.addr_data = 1'b1;
                ctl.mem_rd    = 1'b1;
                step_d        = ST_WB_LOAD;
            end
            ST_STORE: begin
                ctl.addr_data = 1'b1;
                ctl.mem_wr    = 1'b1;
                ctl.retire    = 1'b1;
                step_d        = ST_FETCH;
            end
            ST_WB_R: begin
                ctl.dst_rd = 1'b1;
                ctl.reg_wr = 1'b1;
                ctl.retire = 1'b1;
                step_d     = ST_FETCH;
            end
            ST_WB_I: begin
                ctl.reg_wr = 1'b1;
                ctl.retire = 1'b1;
                step_d     = ST_FETCH;
            end
            ST_WB_LOAD: begin
                ctl.wb_mem = 1'b1;
                ctl.reg_wr = 1'b1;
                ctl.retire = 1'b1;
                step_d     = ST_FETCH;
            end
            default: step_d = ST_FETCH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) step_q <= ST_FETCH;
        else        step_q <= step_d;
    end

    assign step = step_q;
endmodule

// File: rtl/mc_core.sv
module mc_core
    import mc_pkg::*;
#(
    parameter  int MEM_WORDS = 256,
    localparam int MEM_AW    = $clog2(MEM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [MEM_AW-1:0] load_addr,
    input  logic [XW-1:0]     load_data,
    output logic [XW-1:0]     pc_o,
    output logic              retire_o,
    output logic              rf_we_o,
    output logic [RAW-1:0]    rf_waddr_o,
    output logic [XW-1:0]     rf_wdata_o,
    output logic              mem_we_o,
    output logic [XW-1:0]     mem_addr_o,
    output logic [XW-1:0]     mem_wdata_o
);
    dp_t dp_d, dp_q;
    ctl_t ctl;
    step_e cur_step;

    logic [XW-1:0]     ir_word;
    logic [XW-1:0]     mem_q [MEM_WORDS];
    logic [XW-1:0]     mem_addr, mem_rdata;
    logic [MEM_AW-1:0] mem_idx;
    logic [XW-1:0]     imm_ext, src_a, src_b, alu_y, jump_tgt, pc_next;
    logic              alu_zero;
    logic [XW-1:0]     rf_a, rf_b, wb_data;
    logic [RAW-1:0]    wb_addr;
    logic              unused_shamt;

    assign ir_word      = dp_q.ir;
    assign unused_shamt = ^ir_word[10:6];

    mc_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .opcode (ir_word[31:26]),
        .funct  (ir_word[5:0]),
        .ctl    (ctl),
        .step   (cur_step)
    );

    mc_regfile #(.W(XW), .N(1 << RAW)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .ra1   (ir_word[25:21]),
        .ra2   (ir_word[20:16]),
        .rd1   (rf_a),
        .rd2   (rf_b),
        .we    (ctl.reg_wr),
        .wa    (wb_addr),
        .wd    (wb_data)
    );

    mc_alu #(.W(XW)) u_alu (
        .a    (src_a),
        .b    (src_b),
        .fn   (ctl.alu_fn),
        .y    (alu_y),
        .zero (alu_zero)
    );

    always_comb begin
        imm_ext  = {{(XW-16){ir_word[15]}}, ir_word[15:0]};
        src_a    = ctl.srca_reg ? dp_q.a : dp_q.pc;
        unique case (ctl.srcb)
            SRCB_FOUR:   src_b = XW'(4);
            SRCB_IMM:    src_b = imm_ext;
            SRCB_IMM_X4: src_b = {imm_ext[XW-3:0], 2'b00};
            default:     src_b = dp_q.b;
        endcase

        mem_addr  = ctl.addr_data ? dp_q.aluout : dp_q.pc;
        mem_idx   = mem_addr[MEM_AW+1:2];
        mem_rdata = ctl.mem_rd ? mem_q[mem_idx] : '0;

        jump_tgt = {dp_q.pc[XW-1:XW-4], ir_word[25:0], 2'b00};
        unique case (ctl.pcsel)
            PCSEL_HELD: pc_next = dp_q.aluout;
            PCSEL_JUMP: pc_next = jump_tgt;
            default:    pc_next = alu_y;
        endcase

        wb_addr = ctl.dst_rd ? ir_word[15:11] : ir_word[20:16];
        wb_data = ctl.wb_mem ? dp_q.mdr : dp_q.aluout;

        dp_d        = dp_q;
        dp_d.mdr    = mem_rdata;
        dp_d.a      = rf_a;
        dp_d.b      = rf_b;
        dp_d.aluout = alu_y;
        if (ctl.ir_wr) dp_d.ir = mem_rdata;
        if (ctl.pc_wr || (ctl.pc_wr_cond && alu_zero)) dp_d.pc = pc_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dp_q <= '0;
        else        dp_q <= dp_d;
    end

    always_ff @(posedge clk) begin
        if (load_en)         mem_q[load_addr] <= load_data;
        else if (ctl.mem_wr) mem_q[mem_idx]   <= dp_q.b;
    end

    assign pc_o        = dp_q.pc;
    assign retire_o    = ctl.retire;
    assign rf_we_o     = ctl.reg_wr;
    assign rf_waddr_o  = wb_addr;
    assign rf_wdata_o  = wb_data;
    assign mem_we_o    = ctl.mem_wr;
    assign mem_addr_o  = mem_addr;
    assign mem_wdata_o = dp_q.b;
endmodule

// File: rtl/mc_core_chk.sv
module mc_core_chk
    import mc_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input step_e       step,
    input logic [31:0] ir_word,
    input logic [31:0] pc_o,
    input logic        retire_o,
    input logic        rf_we_o,
    input logic        mem_we_o
);
    logic op_known;
    assign op_known = (ir_word[31:26] == OPC_REG) || (ir_word[31:26] == OPC_JMP) ||
                      (ir_word[31:26] == OPC_BEQ) || (ir_word[31:26] == OPC_ADDI) ||
                      (ir_word[31:26] == OPC_LW)  || (ir_word[31:26] == OPC_SW);

    a_r11_retire_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        retire_o |=> !retire_o);

    a_r11_one_writer: assert property (@(posedge clk) disable iff (!rst_n)
        !(rf_we_o && mem_we_o));

    a_r2_fetch_adds_four: assert property (@(posedge clk) disable iff (!rst_n)
        (step == ST_FETCH) |=> (pc_o == $past(pc_o) + 32'd4));

    a_r2_pc_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        pc_o[1:0] == 2'b00);

    a_r10_unknown_refetch: assert property (@(posedge clk) disable iff (!rst_n)
        (step == ST_DECODE && !op_known) |=> (step == ST_FETCH && !retire_o));
endmodule

bind mc_core mc_core_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (cur_step),
    .ir_word  (ir_word),
    .pc_o     (pc_o),
    .retire_o (retire_o),
    .rf_we_o  (rf_we_o),
    .mem_we_o (mem_we_o)
);

// File: tb/tb_mc_core.sv
`timescale 1ns/1ps
module tb_mc_core;
    localparam int MW = 64;
    localparam int AW = $clog2(MW);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load_en = 1'b0;
    logic [AW-1:0] load_addr = '0;
    logic [31:0]   load_data = '0;
    logic [31:0]   pc_o, rf_wdata_o, mem_addr_o, mem_wdata_o;
    logic          retire_o, rf_we_o, mem_we_o;
    logic [4:0]    rf_waddr_o;

    always #2.5 clk = ~clk;

    mc_core #(.MEM_WORDS(MW)) dut (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_addr(load_addr),
        .load_data(load_data), .pc_o(pc_o), .retire_o(retire_o), .rf_we_o(rf_we_o),
        .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o), .mem_we_o(mem_we_o),
        .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o)
    );

    int errors = 0;
    int checks = 0;

    logic [31:0] m_mem [MW];
    logic [31:0] m_reg [32];
    logic [31:0] m_pc;
    int          k = 1;
    int          n = 1;
    logic [31:0] c_ins, c_val, c_addr, c_npc;
    logic [4:0]  c_dst;
    logic        c_known, c_rfw, c_mw;
    string       c_tag;
    string       pc_tag = "R1";
    logic        alias_seen = 1'b0;
    logic [AW-1:0] alias_idx = '0;

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
        return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction
    function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
        return {op, 5'(rs), 5'(rt), 16'(imm)};
    endfunction
    function automatic logic [31:0] rv(logic [4:0] i);
        return (i == 5'd0) ? 32'd0 : m_reg[i];
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic decode_model();
        logic [5:0]  op, fn;
        logic [4:0]  rs, rt, rd;
        logic [31:0] sx, a, b, pc4;
        c_ins = m_mem[(m_pc >> 2) % MW];
        op = c_ins[31:26]; rs = c_ins[25:21]; rt = c_ins[20:16]; rd = c_ins[15:11];
        fn = c_ins[5:0];
        sx = {{16{c_ins[15]}}, c_ins[15:0]};
        a = rv(rs); b = rv(rt); pc4 = m_pc + 32'd4;
        c_known = 1'b1; c_rfw = 1'b0; c_mw = 1'b0; c_npc = pc4;
        c_val = '0; c_addr = '0; c_dst = '0;
        case (op)
            6'h00: begin
                n = 4; c_rfw = 1'b1; c_dst = rd; c_tag = "R3";
                if (rs == 5'd0 || rt == 5'd0) c_tag = "R9";
                case (fn)
                    6'h22: c_val = a - b;
                    6'h24: c_val = a & b;
                    6'h25: c_val = a | b;
                    6'h2A: c_val = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
                    default: c_val = a + b;
                endcase
            end
            6'h23: begin
                n = 5; c_rfw = 1'b1; c_dst = rt; c_tag = "R4";
                c_addr = a + sx;
                c_val = m_mem[(c_addr >> 2) % MW];
                if (alias_seen && ((c_addr >> 2) % MW) == alias_idx) c_tag = "R12";
            end
            6'h2B: begin
                n = 4; c_mw = 1'b1; c_tag = "R5";
                c_addr = a + sx; c_val = b;
                if (c_addr >= MW * 4) c_tag = "R12";
            end
            6'h08: begin
                n = 4; c_rfw = 1'b1; c_dst = rt; c_tag = "R6"; c_val = a + sx;
            end
            6'h04: begin
                n = 3; c_tag = "R7";
                if (a == b) c_npc = pc4 + {sx[29:0], 2'b00};
            end
            6'h02: begin
                n = 3; c_tag = "R8"; c_npc = {pc4[31:28], c_ins[25:0], 2'b00};
            end
            default: begin
                n = 2; c_known = 1'b0; c_tag = "R10";
            end
        endcase
    endtask

    task automatic step_check();
        logic last;
        if (k == 1) decode_model();
        last = (k == n);
        chk((k == 1) ? pc_tag : "R2", "pc_o", pc_o, (k == 1) ? m_pc : m_pc + 32'd4);
        chk(c_tag, "retire_o", {31'd0, retire_o}, {31'd0, last && c_known});
        chk(c_tag, "rf_we_o", {31'd0, rf_we_o}, {31'd0, last && c_rfw});
        chk(c_tag, "mem_we_o", {31'd0, mem_we_o}, {31'd0, last && c_mw});
        chk("R11", "write overlap", {31'd0, rf_we_o && mem_we_o}, 32'd0);
        if (last && c_rfw) begin
            chk(c_tag, "rf_waddr_o", {27'd0, rf_waddr_o}, {27'd0, c_dst});
            chk(c_tag, "rf_wdata_o", rf_wdata_o, c_val);
        end
        if (last && c_mw) begin
            chk(c_tag, "mem_addr_o", mem_addr_o, c_addr);
            chk(c_tag, "mem_wdata_o", mem_wdata_o, c_val);
        end
        if (last) begin
            if (c_rfw && c_dst != 5'd0) m_reg[c_dst] = c_val;
            if (c_mw) begin
                m_mem[(c_addr >> 2) % MW] = c_val;
                if (c_addr >= MW * 4) begin
                    alias_seen = 1'b1;
                    alias_idx  = AW'((c_addr >> 2) % MW);
                end
            end
            m_pc   = c_npc;
            pc_tag = (c_tag == "R7" || c_tag == "R8" || c_tag == "R10") ? c_tag : "R2";
            k = 1;
        end else begin
            k++;
        end
    endtask

    initial begin
        #(5 * 5000);
        errors++;
        checks++;
        $display("FAIL R11 watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < MW; i++) m_mem[i] = 32'd0;
        for (int i = 0; i < 32; i++) m_reg[i] = 32'd0;
        m_pc = 32'd0;
        m_mem[0]  = enc_i(6'h08, 0, 1, 5);
        m_mem[1]  = enc_i(6'h08, 0, 2, -3);
        m_mem[2]  = enc_r(1, 2, 3, 6'h20);
        m_mem[3]  = enc_r(1, 2, 4, 6'h22);
        m_mem[4]  = enc_r(1, 2, 5, 6'h24);
        m_mem[5]  = enc_r(1, 2, 6, 6'h25);
        m_mem[6]  = enc_r(2, 1, 7, 6'h2A);
        m_mem[7]  = enc_r(1, 2, 8, 6'h2A);
        m_mem[8]  = enc_i(6'h2B, 0, 1, 'hC0);
        m_mem[9]  = enc_i(6'h23, 0, 9, 'hC0);
        m_mem[10] = enc_i(6'h08, 0, 0, 7);
        m_mem[11] = enc_r(0, 1, 10, 6'h20);
        m_mem[12] = enc_i(6'h04, 1, 2, 5);
        m_mem[13] = enc_i(6'h04, 1, 10, 2);
        m_mem[14] = enc_i(6'h08, 0, 11, 99);
        m_mem[15] = enc_i(6'h08, 0, 11, 99);
        m_mem[16] = 32'hFC00_0000;
        m_mem[17] = {6'h02, 26'd20};
        m_mem[18] = enc_i(6'h08, 0, 11, 99);
        m_mem[19] = enc_i(6'h08, 0, 11, 99);
        m_mem[20] = enc_i(6'h08, 0, 13, 'hC4);
        m_mem[21] = enc_i(6'h23, 13, 12, -4);
        m_mem[22] = enc_i(6'h2B, 0, 4, 'h1C0);
        m_mem[23] = enc_i(6'h23, 0, 14, 'hC0);
        m_mem[24] = enc_i(6'h04, 0, 0, -1);

        // R1: preload through the load port while reset is held
        for (int i = 0; i < MW; i++) begin
            @(negedge clk);
            load_en   = 1'b1;
            load_addr = AW'(i);
            load_data = m_mem[i];
        end
        @(negedge clk);
        load_en = 1'b0;
        chk("R1", "reset pc_o", pc_o, 32'd0);
        chk("R1", "reset retire_o", {31'd0, retire_o}, 32'd0);
        chk("R1", "reset rf_we_o", {31'd0, rf_we_o}, 32'd0);
        chk("R1", "reset mem_we_o", {31'd0, mem_we_o}, 32'd0);

        @(negedge clk);
        rst_n = 1'b1;
        step_check();
        for (int c = 0; c < 200; c++) begin
            @(negedge clk);
            step_check();
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule